// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the first six bytes of each received frame, which make up the 48-bit destination address, and decides whether the frame is kept. The receive datapath hands it one byte per cycle with a valid strobe and marks the start of every frame with a start strobe. The filter compares the address in three ways. An individual address must equal the programmed station address. A group address is hashed with the Ethernet CRC-32, and the hash selects one bit of a 64-bit programmable table. The all-ones address is treated as broadcast. A promiscuous switch accepts everything.

The verdict is a keep/drop bit and a code naming the rule that matched. Both appear in the cycle after the sixth address byte is taken, and both hold until the next frame start. Any bytes that follow the address are ignored. The block does no buffering and no frame check sequence verification.

Top module: `eth_da_filter`

## Requirements
- R1: Address byte k (k = 0 for the first byte received) is compared with `station_addr[8k+7:8k]`. An individual address that equals the station address in all six bytes is accepted with `match_kind` = 1. Any other individual address is rejected unless R6 applies.
- R2: The group bit is bit 0 of the first address byte. When it is set, the station comparison of R1 is never used, even if all six bytes equal `station_addr`.
- R3: For a group address that is not all ones, a CRC is computed over the six bytes. Each byte is taken least significant bit first. The register starts at FFFFFFFFh and uses the generator 04C11DB7h, held in bit-reflected form with right shifts. There is no final inversion. Bits 31:26 of the reflected register form an index i. The frame is accepted with `match_kind` = 2 when `hash_filter[i]` is 1, and is otherwise rejected unless R6 applies.
- R4: The all-ones address is accepted with `match_kind` = 3 when `bcast_block` is 0.
- R5: When `bcast_block` is 1, the all-ones address matches no rule, and neither the hash table nor the station address is consulted for it.
- R6: When `promisc_en` is 1, every frame is accepted. `match_kind` reports the rule of R1, R3 or R4 if one matched, and 4 otherwise.
- R7: `decision_vld`, `accept` and `match_kind` change in the cycle after the edge that takes the sixth byte with `byte_vld` high. Cycles with `byte_vld` low are skipped. The outputs then hold, and later bytes are ignored, until the edge that sees `frm_start`. That edge clears `decision_vld`.
- R8: A byte presented with `frm_start` and `byte_vld` in the same cycle is address byte 0. A `frm_start` that arrives part way through an address discards the bytes already taken.
- R9: A `hash_filter` of all ones accepts every group address. A `hash_filter` of all zeros rejects every group address except broadcast, assuming `promisc_en` is 0.
- R10: After reset, and whenever `decision_vld` is 0, `accept` is 0 and `match_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle strobe marking a new frame |
| byte_vld | input | 1 | `byte_in` carries a received byte |
| byte_in | input | 8 | Received byte |
| station_addr | input | 48 | Station address, first received byte in bits 7:0 |
| hash_filter | input | 64 | Group address hash table |
| promisc_en | input | 1 | Accept all frames |
| bcast_block | input | 1 | Refuse the all-ones address |
| decision_vld | output | 1 | Verdict is valid |
| accept | output | 1 | Keep the frame |
| match_kind | output | 3 | 0 none, 1 station, 2 hash, 3 broadcast, 4 promiscuous |

## Verification
The bench targets four kinds of mistake, each with a visible symptom:
- Hash path. A wrong bit order or a wrong tap in the CRC selects the wrong table bit. The bench exposes this with random group addresses against sparse tables, which makes such a design accept or drop the wrong frames.
- Group bit. A group address that equals the station address catches a design that lets the group bit fall into the exact-compare path. Such a design wrongly reports a station match.
- Byte sequencing. Gaps in `byte_vld`, bytes that trail the address, a start strobe carrying byte 0, and a restart part way through an address all test when bytes are counted. A design that miscounts would decide early or late, or would overwrite a held verdict.
- Broadcast and promiscuous interplay. With broadcast blocked and promiscuous mode on, the precedence between rules is probed. A design with the rules in the wrong order reports the wrong `match_kind`.

// File: rtl/eth_daf_pkg.sv
package eth_daf_pkg;

    localparam int DEF_ADDR_BYTES = 6;
    localparam int DEF_FILT_BITS  = 64;
    localparam int CRC_W          = 32;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        MK_NONE    = 3'd0,
        MK_UCAST   = 3'd1,
        MK_MCAST   = 3'd2,
        MK_BCAST   = 3'd3,
        MK_PROMISC = 3'd4
    } match_kind_e;

    // Per-byte sequencing event
    typedef struct packed {
        logic take;
        logic first;
        logic last;
    } byte_evt_t;

    // Registered verdict
    typedef struct packed {
        logic        vld;
        logic        acc;
        match_kind_e kind;
    } verdict_t;

    // One byte through the reflected CRC-32, LSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/daf_byte_seq.sv
module daf_byte_seq
    import eth_daf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    localparam int IDX_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic             byte_vld,
    output byte_evt_t        evt,
    output logic [IDX_W-1:0] pos
);

    logic [IDX_W-1:0] idx_q;
    logic             busy_q;

    always_comb begin
        pos       = frm_start ? '0 : idx_q;
        evt.take  = byte_vld && (frm_start || (busy_q && (idx_q < IDX_W'(ADDR_BYTES))));
        evt.first = evt.take && (pos == '0);
        evt.last  = evt.take && (pos == IDX_W'(ADDR_BYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (evt.take) idx_q <= pos + 1'b1;
            else if (frm_start) idx_q <= '0;
            if (evt.last)       busy_q <= 1'b0;
            else if (frm_start) busy_q <= 1'b1;
        end
    end

endmodule

// File: rtl/daf_addr_cmp.sv
module daf_addr_cmp
    import eth_daf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    localparam int IDX_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  byte_evt_t               evt,
    input  logic [IDX_W-1:0]        pos,
    input  logic [7:0]              byte_in,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    eq_now,
    output logic                    ones_now,
    output logic                    grp_now
);

    logic       eq_q, ones_q, grp_q;
    logic [7:0] st_byte;

    always_comb begin
        st_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (pos == IDX_W'(k)) st_byte = station_addr[8*k +: 8];
    end

    always_comb begin
        eq_now   = (evt.first || eq_q)   && (byte_in == st_byte);
        ones_now = (evt.first || ones_q) && (byte_in == 8'hFF);
        grp_now  = evt.first ? byte_in[0] : grp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q   <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (evt.take) begin
            eq_q   <= eq_now;
            ones_q <= ones_now;
            grp_q  <= grp_now;
        end
    end

endmodule

// File: rtl/daf_crc_hash.sv
module daf_crc_hash
    import eth_daf_pkg::*;
#(
    parameter int FILT_BITS = DEF_FILT_BITS,
    localparam int HASH_W = $clog2(FILT_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_evt_t         evt,
    input  logic [7:0]        byte_in,
    output logic [HASH_W-1:0] hash_idx
);

    logic [CRC_W-1:0] crc_q, crc_nx;

    always_comb begin
        crc_nx   = crc_step(evt.first ? CRC_SEED : crc_q, byte_in);
        hash_idx = crc_nx[CRC_W-1 -: HASH_W];
    end

    always_ff @(posedge clk) begin
        if (rst)           crc_q <= CRC_SEED;
        else if (evt.take) crc_q <= crc_nx;
    end

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
    import eth_daf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    parameter int FILT_BITS  = DEF_FILT_BITS,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int IDX_W  = $clog2(ADDR_BYTES + 1),
    localparam int HASH_W = $clog2(FILT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frm_start,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_in,
    input  logic [ADDR_W-1:0]    station_addr,
    input  logic [FILT_BITS-1:0] hash_filter,
    input  logic                 promisc_en,
    input  logic                 bcast_block,
    output logic                 decision_vld,
    output logic                 accept,
    output logic [2:0]           match_kind
);

    byte_evt_t         evt;
    logic [IDX_W-1:0]  pos;
    logic              eq_now, ones_now, grp_now;
    logic [HASH_W-1:0] hash_idx;
    match_kind_e       kind_nx;
    verdict_t          verdict_q;

    daf_byte_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
        .evt(evt), .pos(pos)
    );

    daf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
        .clk(clk), .rst(rst), .evt(evt), .pos(pos), .byte_in(byte_in),
        .station_addr(station_addr), .eq_now(eq_now), .ones_now(ones_now),
        .grp_now(grp_now)
    );

    daf_crc_hash #(.FILT_BITS(FILT_BITS)) u_hash (
        .clk(clk), .rst(rst), .evt(evt), .byte_in(byte_in), .hash_idx(hash_idx)
    );

    // Rule precedence: broadcast, group hash, station, promiscuous
    always_comb begin
        kind_nx = MK_NONE;
        if (grp_now && ones_now) begin
            if (!bcast_block) kind_nx = MK_BCAST;
        end else if (grp_now) begin
            if (hash_filter[hash_idx]) kind_nx = MK_MCAST;
        end else if (eq_now) begin
            kind_nx = MK_UCAST;
        end
        if (kind_nx == MK_NONE && promisc_en) kind_nx = MK_PROMISC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '{vld: 1'b0, acc: 1'b0, kind: MK_NONE};
        end else if (evt.last) begin
            verdict_q <= '{vld: 1'b1, acc: (kind_nx != MK_NONE), kind: kind_nx};
        end else if (frm_start) begin
            verdict_q <= '{vld: 1'b0, acc: 1'b0, kind: MK_NONE};
        end
    end

    assign decision_vld = verdict_q.vld;
    assign accept       = verdict_q.acc;
    assign match_kind   = verdict_q.kind;

endmodule

// File: rtl/eth_da_filter_chk.sv
module eth_da_filter_chk
    import eth_daf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frm_start,
    input logic       byte_vld,
    input logic       promisc_en,
    input logic       bcast_block,
    input logic       decision_vld,
    input logic       accept,
    input logic [2:0] match_kind
);

    a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
        frm_start |=> !decision_vld);

    a_r7_verdict_held: assert property (@(posedge clk) disable iff (rst)
        (decision_vld && !frm_start) |=> (decision_vld && $stable(accept) && $stable(match_kind)));

    a_r7_after_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(decision_vld) |-> $past(byte_vld));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !decision_vld |-> (!accept && match_kind == 3'd0));

    a_r6_promisc_keeps: assert property (@(posedge clk) disable iff (rst)
        ($rose(decision_vld) && $past(promisc_en)) |-> accept);

    a_r5_bcast_blocked: assert property (@(posedge clk) disable iff (rst)
        ($rose(decision_vld) && $past(bcast_block)) |-> (match_kind != 3'(MK_BCAST)));

endmodule

bind eth_da_filter eth_da_filter_chk u_chk (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
    .promisc_en(promisc_en), .bcast_block(bcast_block),
    .decision_vld(decision_vld), .accept(accept), .match_kind(match_kind)
);

// File: tb/eth_da_filter_tb.sv
module eth_da_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_start = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [47:0] station_addr = 48'h0;
    logic [63:0] hash_filter = 64'h0;
    logic        promisc_en = 1'b0;
    logic        bcast_block = 1'b0;
    logic        decision_vld;
    logic        accept;
    logic [2:0]  match_kind;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    eth_da_filter u_dut (
        .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .station_addr(station_addr), .hash_filter(hash_filter),
        .promisc_en(promisc_en), .bcast_block(bcast_block),
        .decision_vld(decision_vld), .accept(accept), .match_kind(match_kind)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Forward-form CRC, reversed at the end to obtain the reflected index
    function automatic int hash_of(input logic [47:0] da);
        logic [31:0] f = 32'hFFFF_FFFF;
        logic        fb;
        for (int k = 0; k < 6; k++)
            for (int b = 0; b < 8; b++) begin
                fb = f[31] ^ da[8*k + b];
                f  = f << 1;
                if (fb) f = f ^ 32'h04C1_1DB7;
            end
        return {26'd0, f[0], f[1], f[2], f[3], f[4], f[5]};
    endfunction

    function automatic int model_kind(input logic [47:0] da);
        int k = 0;
        if (da[0] && da == 48'hFFFF_FFFF_FFFF) begin
            if (!bcast_block) k = 3;
        end else if (da[0]) begin
            if (hash_filter[hash_of(da)]) k = 2;
        end else if (da == station_addr) k = 1;
        if (k == 0 && promisc_en) k = 4;
        return k;
    endfunction

    task automatic send_frame(input logic [47:0] da, input bit lead, input int gapmax,
                              input string req);
        int first;
        int ek;
        ek = model_kind(da);
        @(negedge clk);
        frm_start = 1'b1;
        byte_vld  = lead;
        byte_in   = da[7:0];
        first     = lead ? 1 : 0;
        @(negedge clk);
        frm_start = 1'b0;
        chk({req, " R7 start clears"}, int'(decision_vld), 0);
        for (int k = first; k < 6; k++) begin
            int g = (gapmax > 0) ? int'($urandom_range(gapmax)) : 0;
            for (int j = 0; j < g; j++) begin
                byte_vld = 1'b0;
                byte_in  = 8'($urandom);
                @(negedge clk);
            end
            if (k == 5) chk({req, " R7 not early"}, int'(decision_vld), 0);
            byte_vld = 1'b1;
            byte_in  = da[8*k +: 8];
            @(negedge clk);
        end
        byte_vld = 1'b0;
        chk({req, " R7 valid"}, int'(decision_vld), 1);
        chk({req, " accept"}, int'(accept), (ek != 0) ? 1 : 0);
        chk({req, " kind"}, int'(match_kind), ek);
        // Trailing bytes are ignored, verdict holds (R7)
        for (int j = 0; j < 3; j++) begin
            byte_vld = 1'b1;
            byte_in  = 8'($urandom);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        chk({req, " R7 hold kind"}, int'(match_kind), ek);
        chk({req, " R7 hold vld"}, int'(decision_vld), 1);
    endtask

    task automatic partial(input int n);
        @(negedge clk);
        frm_start = 1'b1;
        byte_vld  = 1'b0;
        @(negedge clk);
        frm_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1'b1;
            byte_in  = 8'($urandom);
            @(negedge clk);
        end
        byte_vld = 1'b0;
    endtask

    function automatic logic [47:0] rnd48();
        return {16'($urandom), 32'($urandom)};
    endfunction

    initial begin
        logic [47:0] da;
        void'($urandom(32'd20240611));
        station_addr = 48'h5634_12AB_CD02;
        repeat (3) @(negedge clk);
        chk("R10 reset vld", int'(decision_vld), 0);
        chk("R10 reset accept", int'(accept), 0);
        chk("R10 reset kind", int'(match_kind), 0);
        rst = 1'b0;

        send_frame(station_addr, 1'b0, 0, "R1 station exact");
        send_frame(station_addr ^ 48'h0100_0000_0000, 1'b0, 2, "R1 last byte differs");
        send_frame(station_addr, 1'b1, 3, "R8 byte with start R1");

        station_addr = 48'h0000_0000_0001;
        hash_filter  = 64'h0;
        send_frame(48'h0000_0000_0001, 1'b0, 0, "R2 group equals station");
        station_addr = 48'h5634_12AB_CD02;

        hash_filter = 64'hFFFF_FFFF_FFFF_FFFF;
        send_frame(rnd48() | 48'h1, 1'b0, 1, "R9 all-ones table");
        hash_filter = 64'h0;
        send_frame(rnd48() | 48'h1, 1'b0, 1, "R9 all-zeros table");
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, 0, "R9 R4 broadcast zero table");

        bcast_block = 1'b1;
        hash_filter = 64'hFFFF_FFFF_FFFF_FFFF;
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, 0, "R5 broadcast blocked");
        promisc_en = 1'b1;
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, 0, "R5 R6 blocked promisc");
        send_frame(station_addr, 1'b0, 0, "R6 station under promisc");
        send_frame(48'h1234_5678_9A00, 1'b0, 0, "R6 stranger under promisc");
        promisc_en  = 1'b0;
        bcast_block = 1'b0;

        // One-hot table on the computed index
        da = 48'h0000_5E00_0001;
        hash_filter = 64'h1 << hash_of(da);
        send_frame(da, 1'b0, 0, "R3 single table bit hit");
        hash_filter = ~(64'h1 << hash_of(da));
        send_frame(da, 1'b0, 0, "R3 single table bit miss");

        partial(3);
        send_frame(station_addr, 1'b0, 0, "R8 restart mid address");

        for (int t = 0; t < 250; t++) begin
            int sel = int'($urandom_range(5));
            hash_filter  = {32'($urandom), 32'($urandom)} & {32'($urandom), 32'($urandom)};
            promisc_en   = ($urandom_range(7) == 0);
            bcast_block  = $urandom_range(1);
            station_addr = rnd48() & ~48'h1;
            case (sel)
                0:       da = station_addr;
                1:       da = rnd48() & ~48'h1;
                2, 3:    da = rnd48() | 48'h1;
                4:       da = 48'hFFFF_FFFF_FFFF;
                default: da = station_addr ^ (48'h2 << $urandom_range(46));
            endcase
            if (sel == 2) partial(int'($urandom_range(5)));
            send_frame(da, $urandom_range(1), 2, "R1 R3 R4 R6 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule